// File: doc/BRIEF.md
# Byte-Lane Data Bus Inversion Codec

This block sits in the data path between a memory controller and its physical layer. It splits a 16- or 32-bit data word into independent 8-bit lanes and gives each lane one mask wire that carries an inversion flag. On the write side, each byte that holds five or more 1 bits is sent complemented, and that lane's flag is raised. This limits the number of high bits driven onto the bus. On the read side, each received byte whose flag is high is complemented back to its true value.

Write inversion and read inversion have separate enable bits. Both enable bits are set at reset, and a one-cycle configuration strobe can load new values. The encoded write data, its flags and a valid bit are registered together, so they appear one clock after the input is accepted. The read decode is purely combinational.

Top module: `dbi_codec`

## Requirements
- R1: The width `WIDTH` may be 16 or 32. Bits [8k+7:8k] form lane k, and flag bit k belongs to lane k. Each lane is encoded and decoded using only its own byte and flag.
- R2: With write inversion enabled, an accepted byte with five or more 1 bits leaves the block complemented, and its flag bit is 1.
- R3: With write inversion enabled, an accepted byte with four or fewer 1 bits leaves the block unchanged, and its flag bit is 0. This includes every byte with exactly four 1 bits.
- R4: `wrValidOut` is high exactly one clock after a cycle in which `wrValidIn` is high. The encoded data and flags change only on such a cycle.
- R5: With read inversion enabled, a read byte whose flag bit is 1 is output complemented. A read byte whose flag bit is 0 passes through unchanged, in the same cycle.
- R6: With write inversion disabled, accepted data passes through unchanged and every flag bit is 0.
- R7: With read inversion disabled, read data passes through unchanged whatever the flag inputs are.
- R8: After reset, `wrValidOut`, `wrDataOut` and `wrFlagOut` are 0, and both inversion enables are on.
- R9: A configuration load (`cfgLoad` high) takes effect on the next clock. Write data accepted in the same cycle as the load is still encoded with the previous setting.
- R10: For every byte value 0 to 255 on every lane, encoding and then decoding with both enables on returns the original byte. The flag equals (ones count >= 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Loads both enable bits this cycle |
| cfgWrInvEn | input | 1 | New write inversion enable |
| cfgRdInvEn | input | 1 | New read inversion enable |
| wrValidIn | input | 1 | Write data valid, accepted on the clock edge |
| wrDataIn | input | WIDTH | Write data from the controller |
| wrValidOut | output | 1 | Encoded write data valid |
| wrDataOut | output | WIDTH | Encoded write data toward the bus |
| wrFlagOut | output | WIDTH/8 | Per-lane inversion flag driven on the mask wires |
| rdDataIn | input | WIDTH | Raw read data from the bus |
| rdFlagIn | input | WIDTH/8 | Per-lane inversion flag received on the mask wires |
| rdDataOut | output | WIDTH | Restored read data |

## Verification
The bench aims at the threshold boundary, using bytes with exactly four and exactly five 1 bits. A design with an off-by-one comparison would invert the four-bit byte or pass the five-bit byte unchanged. Mixed words place inverting and non-inverting lanes side by side, which exposes a lane whose flag or byte is wired to a neighbour. The configuration tests disable each direction separately and load a new setting in the same cycle as write data. A design that ignored an enable, kept a flag raised while disabled, or applied a load one cycle early would produce the wrong byte or flag there. A full sweep of all 256 byte values through encode and decode catches any byte that does not return to its original value.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int LANE_BITS = 8;
  localparam int INV_THRESHOLD = 5;

  typedef struct packed {
    logic capture;    // accept write data this cycle
    logic wrInvert;   // write inversion enabled
    logic rdInvert;   // read inversion enabled
  } ctrlStrobes_t;
endpackage

// File: rtl/dbi_ctrl.sv
module dbi_ctrl
  import dbi_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgLoad,
  input  logic         cfgWrInvEn,
  input  logic         cfgRdInvEn,
  input  logic         wrValidIn,
  output ctrlStrobes_t strobes
);
  logic wrEnReg;
  logic rdEnReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEnReg <= 1'b1;
      rdEnReg <= 1'b1;
    end else if (cfgLoad) begin
      wrEnReg <= cfgWrInvEn;
      rdEnReg <= cfgRdInvEn;
    end
  end

  always_comb begin
    strobes.capture  = wrValidIn;
    strobes.wrInvert = wrEnReg;
    strobes.rdInvert = rdEnReg;
  end

  // R9
  cfg_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (strobes.wrInvert == $past(cfgWrInvEn)) && (strobes.rdInvert == $past(cfgRdInvEn)));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(strobes.wrInvert) && $stable(strobes.rdInvert));
endmodule

// File: rtl/dbi_lane.sv
module dbi_lane
  import dbi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [LANE_BITS-1:0] wrByte,
  output logic [LANE_BITS-1:0] wrByteOut,
  output logic                 wrFlagOut,
  input  logic [LANE_BITS-1:0] rdByte,
  input  logic                 rdFlag,
  output logic [LANE_BITS-1:0] rdByteOut
);
  localparam int CNT_W = $clog2(LANE_BITS + 1);

  logic [CNT_W-1:0] onesCount;
  logic             invertNow;

  always_comb begin
    onesCount = '0;
    for (int i = 0; i < LANE_BITS; i++) begin
      onesCount = onesCount + CNT_W'(wrByte[i]);
    end
    invertNow = strobes.wrInvert && (onesCount >= CNT_W'(INV_THRESHOLD));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrByteOut <= '0;
      wrFlagOut <= 1'b0;
    end else if (strobes.capture) begin
      wrByteOut <= invertNow ? ~wrByte : wrByte;
      wrFlagOut <= invertNow;
    end
  end

  always_comb begin
    rdByteOut = (strobes.rdInvert && rdFlag) ? ~rdByte : rdByte;
  end

  // R2
  flag_sparse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrFlagOut |-> ($countones(wrByteOut) <= 3));

  // R3
  enc_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.wrInvert) |=> ($countones(wrByteOut) <= 4));

  // R6
  wr_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.wrInvert) |=> (!wrFlagOut && wrByteOut == $past(wrByte)));

  // R4
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(wrByteOut) && $stable(wrFlagOut)));

  // R7
  always_comb begin
    if (rstN === 1'b1 && strobes.rdInvert === 1'b0) begin
      rd_bypass_chk: assert (rdByteOut == rdByte);
    end
  end
endmodule

// File: rtl/dbi_datapath.sv
module dbi_datapath
  import dbi_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [WIDTH-1:0]     wrDataIn,
  output logic                 wrValidOut,
  output logic [WIDTH-1:0]     wrDataOut,
  output logic [WIDTH/8-1:0]   wrFlagOut,
  input  logic [WIDTH-1:0]     rdDataIn,
  input  logic [WIDTH/8-1:0]   rdFlagIn,
  output logic [WIDTH-1:0]     rdDataOut
);
  localparam int LANES = WIDTH / LANE_BITS;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    dbi_lane u_lane (
      .clk       (clk),
      .rstN      (rstN),
      .strobes   (strobes),
      .wrByte    (wrDataIn[g*LANE_BITS +: LANE_BITS]),
      .wrByteOut (wrDataOut[g*LANE_BITS +: LANE_BITS]),
      .wrFlagOut (wrFlagOut[g]),
      .rdByte    (rdDataIn[g*LANE_BITS +: LANE_BITS]),
      .rdFlag    (rdFlagIn[g]),
      .rdByteOut (rdDataOut[g*LANE_BITS +: LANE_BITS])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrValidOut <= 1'b0;
    else       wrValidOut <= strobes.capture;
  end

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> wrValidOut);

  // R4
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> !wrValidOut);
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
  import dbi_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgLoad,
  input  logic                 cfgWrInvEn,
  input  logic                 cfgRdInvEn,
  input  logic                 wrValidIn,
  input  logic [WIDTH-1:0]     wrDataIn,
  output logic                 wrValidOut,
  output logic [WIDTH-1:0]     wrDataOut,
  output logic [WIDTH/8-1:0]   wrFlagOut,
  input  logic [WIDTH-1:0]     rdDataIn,
  input  logic [WIDTH/8-1:0]   rdFlagIn,
  output logic [WIDTH-1:0]     rdDataOut
);
  ctrlStrobes_t strobes;

  dbi_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgLoad    (cfgLoad),
    .cfgWrInvEn (cfgWrInvEn),
    .cfgRdInvEn (cfgRdInvEn),
    .wrValidIn  (wrValidIn),
    .strobes    (strobes)
  );

  dbi_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrDataIn   (wrDataIn),
    .wrValidOut (wrValidOut),
    .wrDataOut  (wrDataOut),
    .wrFlagOut  (wrFlagOut),
    .rdDataIn   (rdDataIn),
    .rdFlagIn   (rdFlagIn),
    .rdDataOut  (rdDataOut)
  );

  // R1
  initial begin
    width_chk: assert (WIDTH == 16 || WIDTH == 32);
  end
endmodule

// File: tb/sim_dbi_codec.sv
module sim_dbi_codec;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NV = 7;

  // stimulus, expected data, expected flags (lane 3 is the top byte)
  localparam logic [31:0] VEC_IN   [NV] = '{32'h00000000, 32'hFFFFFFFF, 32'h0F0F0F0F,
                                           32'h1F0F3E07, 32'h80FE7F01, 32'hF0F1AA55, 32'h1E3C78F8};
  localparam logic [31:0] VEC_DATA [NV] = '{32'h00000000, 32'h00000000, 32'h0F0F0F0F,
                                           32'hE00FC107, 32'h80018001, 32'hF00EAA55, 32'h1E3C7807};
  localparam logic [3:0]  VEC_FLAG [NV] = '{4'b0000, 4'b1111, 4'b0000,
                                           4'b1010, 4'b0110, 4'b0100, 4'b0001};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0, cfgWrInvEn = 1'b1, cfgRdInvEn = 1'b1;
  logic wrValidIn = 1'b0;
  logic [W-1:0] wrDataIn = '0;
  logic wrValidOut;
  logic [W-1:0] wrDataOut;
  logic [W/8-1:0] wrFlagOut;
  logic [W-1:0] rdDataIn = '0;
  logic [W/8-1:0] rdFlagIn = '0;
  logic [W-1:0] rdDataOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbi_codec #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgWrInvEn(cfgWrInvEn),
    .cfgRdInvEn(cfgRdInvEn), .wrValidIn(wrValidIn), .wrDataIn(wrDataIn),
    .wrValidOut(wrValidOut), .wrDataOut(wrDataOut), .wrFlagOut(wrFlagOut),
    .rdDataIn(rdDataIn), .rdFlagIn(rdFlagIn), .rdDataOut(rdDataOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one word at a negedge, let the edge accept it, sample 1ns later
  task automatic sendWrite(input logic [W-1:0] d, input logic load, input logic wEn, input logic rEn);
    @(negedge clk);
    wrDataIn = d; wrValidIn = 1'b1;
    cfgLoad = load; cfgWrInvEn = wEn; cfgRdInvEn = rEn;
    @(posedge clk); #1;
    wrValidIn = 1'b0; cfgLoad = 1'b0;
  endtask

  function automatic int popcnt(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(b[i]);
    return n;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      testsFailed++; testsRun++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R8 reset state
    check("R8 valid", 64'(wrValidOut), 64'd0);
    check("R8 data", 64'(wrDataOut), 64'd0);
    check("R8 flags", 64'(wrFlagOut), 64'd0);

    // R1 R2 R3 table of mixed lanes, enables on since reset (R8)
    for (int v = 0; v < NV; v++) begin
      sendWrite(VEC_IN[v], 1'b0, 1'b1, 1'b1);
      check("R2/R3 data", 64'(wrDataOut), 64'(VEC_DATA[v]));
      check("R1 flags", 64'(wrFlagOut), 64'(VEC_FLAG[v]));
      check("R4 valid", 64'(wrValidOut), 64'd1);
    end

    // R4 idle cycle: valid drops, data holds
    @(posedge clk); #1;
    check("R4 valid drop", 64'(wrValidOut), 64'd0);
    check("R4 data hold", 64'(wrDataOut), 64'h1E3C7807);

    // R5 read decode with mixed flags
    @(negedge clk); rdDataIn = 32'h00FF0F3C; rdFlagIn = 4'b1010; #1;
    check("R5 read mix", 64'(rdDataOut), 64'hFFFFF03C);

    // R9 load disable together with data: old (on) setting applies
    sendWrite(32'hFFFFFFFF, 1'b1, 1'b0, 1'b1);
    check("R9 same-cycle data", 64'(wrDataOut), 64'h00000000);
    check("R9 same-cycle flags", 64'(wrFlagOut), 64'hF);

    // R6 write inversion off
    sendWrite(32'hFFF81F07, 1'b0, 1'b0, 1'b1);
    check("R6 bypass data", 64'(wrDataOut), 64'hFFF81F07);
    check("R6 flags low", 64'(wrFlagOut), 64'd0);

    // R7 read inversion off, write back on
    sendWrite(32'h00000000, 1'b1, 1'b1, 1'b0);
    @(negedge clk); rdDataIn = 32'hA55A0FF0; rdFlagIn = 4'b1111; #1;
    check("R7 ignore flags", 64'(rdDataOut), 64'hA55A0FF0);
    sendWrite(32'h1F1F1F1F, 1'b1, 1'b1, 1'b1);
    check("R9 write re-enabled", 64'(wrDataOut), 64'hE0E0E0E0);
    #1;
    check("R9 read re-enabled", 64'(rdDataOut), 64'h5AA5F00F);

    // R10 sweep all byte values, each lane carries a different byte
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] word;
      logic [3:0] expFlag;
      logic [7:0] b;
      for (int k = 0; k < 4; k++) begin
        b = 8'(v + 67 * k);
        word[k*8 +: 8] = b;
        expFlag[k] = (popcnt(b) >= 5);
      end
      sendWrite(word, 1'b0, 1'b1, 1'b1);
      check("R10 flag vs ones", 64'(wrFlagOut), 64'(expFlag));
      @(negedge clk); rdDataIn = wrDataOut; rdFlagIn = wrFlagOut; #1;
      check("R10 round trip", 64'(rdDataOut), 64'(word));
    end

    // R8 reset again restores enables and clears outputs
    sendWrite(32'h00000000, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check("R8 reset clears valid", 64'(wrValidOut), 64'd0);
    @(negedge clk); rstN = 1'b1;
    sendWrite(32'hFFFFFFFF, 1'b0, 1'b0, 1'b0);
    check("R8 write enable back on", 64'(wrDataOut), 64'h00000000);
    @(negedge clk); rdDataIn = 32'h000000FF; rdFlagIn = 4'b0001; #1;
    check("R8 read enable back on", 64'(rdDataOut), 64'h00000000);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule